// File: doc/BRIEF.md
# Speculative Register Checkpoint Unit

This block lets a processor run a group of translated instructions speculatively and then either keep or discard the results. It holds two copies of the register file. The working copy is read and written by the pipeline. The shadow copy is the last known-good state. Stores made during a group do not go to memory at once. They wait in a small ordered buffer, and the addresses of loads issued during the group are recorded.

When the group ends cleanly, the control logic pulses commit. The shadow copy takes the working state, and the held stores are written out to memory one per cycle. When the group raised an exception, the control logic pulses rollback. The working registers return to the shadow values, and the held stores and recorded loads are thrown away.

A store to an address that a recorded load already read raises an alias flag. The flag does not undo anything by itself; the control logic decides whether to roll back. A store that arrives while the buffer is full is dropped and raises an overflow flag.

Top module: `spec_ckpt_unit`

## Requirements
- R1: After reset:
  - `busy`, `overflow`, `aliasViol` and `memWrEn` are 0.
  - Every working register reads 0, and every shadow register is 0.
- R2: When `wrEn` is high at a clock edge, `wrData` is stored into working register `wrAddr`. `rdData` always shows working register `rdAddr` with no clock delay.
- R3: An accepted rollback copies all 64 shadow registers into the working registers at one edge. A register write in the same cycle is dropped.
- R4: An accepted commit copies the working registers, as they were before the edge, into the shadow. A write in the commit cycle changes only the working copy.
- R5: Enqueued stores never reach the memory port before a commit: `memWrEn` stays 0.
- R6: Draining after a commit:
  - A commit that finds N stores held (N > 0) sets `busy` for exactly N cycles, starting the cycle after the commit.
  - In each of those cycles, `memWrEn` is 1 and one store appears on `memWrAddr`/`memWrData`, oldest first.
  - A commit with an empty buffer leaves `busy` low.
- R7: An accepted rollback discards every held store. A later commit writes nothing.
- R8: Overflow:
  - The buffer holds 8 stores. A store that arrives while 8 are held is dropped and sets `overflow`.
  - `overflow` stays set until an accepted commit or rollback clears it.
  - The 8 stores already held still drain intact.
- R9: Alias detection:
  - A store whose address equals a recorded load address sets `aliasViol` at the next edge.
  - The flag stays set until an accepted commit or rollback.
  - The store itself is still buffered.
- R10: Load tracking:
  - The tracker records up to 8 distinct load addresses, compared on all address bits.
  - A load to an address already recorded uses no new slot.
  - A load to a new address while all 8 slots are in use sets `aliasViol`, as a conservative choice.
- R11: An accepted commit or rollback clears every recorded load address and both flags. A store to a previously recorded address then raises no alias.
- R12: Request priority:
  - Commit and rollback requests are ignored while `busy` is high.
  - When both arrive together, rollback wins and no commit takes place.
- R13: Stores enqueued while a drain is under way are held for the next group. They are written only by a later commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdAddr | input | 6 | Working register read index |
| rdData | output | 32 | Working register read value (combinational) |
| wrEn | input | 1 | Working register write enable |
| wrAddr | input | 6 | Working register write index |
| wrData | input | 32 | Working register write value |
| stEn | input | 1 | Enqueue a speculative store |
| stAddr | input | 16 | Store address |
| stData | input | 32 | Store data |
| ldEn | input | 1 | Record a speculative load |
| ldAddr | input | 16 | Load address to record |
| commitReq | input | 1 | Group finished without exception |
| rollbackReq | input | 1 | Group raised an exception |
| memWrEn | output | 1 | Memory write strobe during drain |
| memWrAddr | output | 16 | Memory write address |
| memWrData | output | 32 | Memory write data |
| busy | output | 1 | Drain in progress |
| overflow | output | 1 | A store was dropped because the buffer was full |
| aliasViol | output | 1 | A store hit a recorded load, or the tracker overflowed |

## Verification
The embedded assertions check properties that must hold on every cycle:
- the buffer fill stays bounded, and no enqueue is accepted when the buffer is full;
- no pop happens from an empty buffer;
- the working copy and the shadow copy agree right after a rollback, and after a commit that carries no write;
- the drain countdown falls by one each cycle and is never reloaded mid-drain;
- the flags behave as sticky bits.

Only the bench's scenarios can show the rest:
- the drain order on the memory port and the exact length of `busy`;
- that a write in the commit or rollback cycle lands in the right copy;
- that a repeated load uses no tracker slot;
- that stores enqueued during a drain wait for the next commit.

// File: rtl/spec_ckpt_pkg.sv
package spec_ckpt_pkg;

  // Strobes from the control module to the datapath, one cycle wide each.
  typedef struct packed {
    logic doCommit;    // copy working -> shadow, clear tracker
    logic doRollback;  // copy shadow -> working, empty buffer, clear tracker
    logic doPush;      // append store to buffer
    logic doPop;       // retire buffer head to memory
    logic doTrack;     // record load address in a free slot
  } ckptStrobe_t;

endpackage

// File: rtl/spec_ckpt_datapath.sv
module spec_ckpt_datapath
  import spec_ckpt_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int SB_DEPTH = 8,
  parameter int LT_DEPTH = 8,
  localparam int REG_AW  = $clog2(NUM_REGS),
  localparam int SB_PW   = $clog2(SB_DEPTH),
  localparam int SB_CW   = $clog2(SB_DEPTH + 1),
  localparam int LT_IW   = $clog2(LT_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ckptStrobe_t       strobe,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [REG_AW-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic [SB_CW-1:0]  sbCount,
  output logic              stHitsLoad,
  output logic              ldTracked,
  output logic              ltFull,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData
);

  // ---------------- register files ----------------
  logic [DATA_W-1:0] workRf   [NUM_REGS];
  logic [DATA_W-1:0] shadowRf [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        workRf[i]   <= '0;
        shadowRf[i] <= '0;
      end
    end else if (strobe.doRollback) begin
      for (int i = 0; i < NUM_REGS; i++) workRf[i] <= shadowRf[i];
    end else begin
      if (wrEn) workRf[wrAddr] <= wrData;
      if (strobe.doCommit) begin
        for (int i = 0; i < NUM_REGS; i++) shadowRf[i] <= workRf[i];
      end
    end
  end

  assign rdData = workRf[rdAddr];

  logic [DATA_W-1:0] workAtRd, shadowAtRd;
  assign workAtRd   = workRf[rdAddr];
  assign shadowAtRd = shadowRf[rdAddr];

  // ---------------- gated store buffer ----------------
  logic [ADDR_W-1:0] sbAddr [SB_DEPTH];
  logic [DATA_W-1:0] sbData [SB_DEPTH];
  logic [SB_PW-1:0]  headPtr, tailPtr;

  function automatic logic [SB_PW-1:0] ptrNext(input logic [SB_PW-1:0] p);
    return (p == SB_PW'(SB_DEPTH - 1)) ? '0 : p + SB_PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || strobe.doRollback) begin
      headPtr <= '0;
      tailPtr <= '0;
      sbCount <= '0;
    end else begin
      if (strobe.doPush) begin
        sbAddr[tailPtr] <= stAddr;
        sbData[tailPtr] <= stData;
        tailPtr         <= ptrNext(tailPtr);
      end
      if (strobe.doPop) headPtr <= ptrNext(headPtr);
      sbCount <= sbCount + SB_CW'(strobe.doPush) - SB_CW'(strobe.doPop);
    end
  end

  assign headAddr = sbAddr[headPtr];
  assign headData = sbData[headPtr];

  // ---------------- speculative load tracker ----------------
  logic [LT_DEPTH-1:0] ltValid;
  logic [ADDR_W-1:0]   ltAddr [LT_DEPTH];
  logic [LT_IW-1:0]    freeIdx;

  always_comb begin
    stHitsLoad = 1'b0;
    ldTracked  = 1'b0;
    freeIdx    = '0;
    for (int i = 0; i < LT_DEPTH; i++) begin
      if (ltValid[i] && (ltAddr[i] == stAddr)) stHitsLoad = 1'b1;
      if (ltValid[i] && (ltAddr[i] == ldAddr)) ldTracked  = 1'b1;
    end
    for (int i = LT_DEPTH - 1; i >= 0; i--) begin
      if (!ltValid[i]) freeIdx = LT_IW'(i);
    end
  end

  assign ltFull = &ltValid;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.doRollback || strobe.doCommit) begin
      ltValid <= '0;
    end else if (strobe.doTrack) begin
      ltValid[freeIdx] <= 1'b1;
      ltAddr[freeIdx]  <= ldAddr;
    end
  end

  // ---------------- assertions ----------------
  // R6
  sb_count_bounded_chk: assert property (@(posedge clk) disable iff (!rstN)
    sbCount <= SB_CW'(SB_DEPTH));

  // R8
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doPush |-> sbCount < SB_CW'(SB_DEPTH));

  // R5
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doPop |-> sbCount != '0);

  // R3
  rollback_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doRollback |=> workAtRd == shadowAtRd);

  // R4
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doCommit && !wrEn |=> workAtRd == shadowAtRd);

  // R7
  rollback_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doRollback |=> sbCount == '0);

  // R11
  tracker_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doCommit || strobe.doRollback) |=> ltValid == '0);

endmodule

// File: rtl/spec_ckpt_ctrl.sv
module spec_ckpt_ctrl
  import spec_ckpt_pkg::*;
#(
  parameter int SB_DEPTH = 8,
  localparam int SB_CW   = $clog2(SB_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             commitReq,
  input  logic             rollbackReq,
  input  logic             stEn,
  input  logic             ldEn,
  input  logic [SB_CW-1:0] sbCount,
  input  logic             stHitsLoad,
  input  logic             ldTracked,
  input  logic             ltFull,
  output ckptStrobe_t      strobe,
  output logic             busy,
  output logic             overflow,
  output logic             aliasViol
);

  typedef enum logic {ST_IDLE, ST_DRAIN} ctrlState_t;

  ctrlState_t       state;
  logic [SB_CW-1:0] drainLeft;
  logic             accRollback, accCommit, accAny, sbFull;

  assign busy        = (state == ST_DRAIN);
  assign sbFull      = (sbCount >= SB_CW'(SB_DEPTH));
  assign accRollback = rollbackReq && !busy;
  assign accCommit   = commitReq && !rollbackReq && !busy;
  assign accAny      = accRollback || accCommit;

  always_comb begin
    strobe.doRollback = accRollback;
    strobe.doCommit   = accCommit;
    strobe.doPush     = stEn && !accRollback && !sbFull;
    strobe.doPop      = busy;
    strobe.doTrack    = ldEn && !accAny && !ldTracked && !ltFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      drainLeft <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accCommit && (sbCount != '0)) begin
            state     <= ST_DRAIN;
            drainLeft <= sbCount;
          end
        end
        ST_DRAIN: begin
          drainLeft <= drainLeft - SB_CW'(1);
          if (drainLeft == SB_CW'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || accAny) begin
      overflow  <= 1'b0;
      aliasViol <= 1'b0;
    end else begin
      if (stEn && sbFull) overflow <= 1'b1;
      if ((stEn && stHitsLoad) || (ldEn && ltFull && !ldTracked)) aliasViol <= 1'b1;
    end
  end

  // ---------------- assertions ----------------
  // R6
  drain_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && drainLeft == SB_CW'(1) |=> !busy);

  // R12
  drain_countdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && drainLeft > SB_CW'(1) |=> busy && (drainLeft == $past(drainLeft) - SB_CW'(1)));

  // R9
  alias_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stEn && stHitsLoad && !accAny |=> aliasViol);

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !accAny |=> overflow);

  // R11
  flags_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    accAny |=> !overflow && !aliasViol);

endmodule

// File: rtl/spec_ckpt_unit.sv
module spec_ckpt_unit
  import spec_ckpt_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int SB_DEPTH = 8,
  parameter int LT_DEPTH = 8,
  localparam int REG_AW  = $clog2(NUM_REGS),
  localparam int SB_CW   = $clog2(SB_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stEn,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic              ldEn,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              commitReq,
  input  logic              rollbackReq,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              busy,
  output logic              overflow,
  output logic              aliasViol
);

  ckptStrobe_t      strobe;
  logic [SB_CW-1:0] sbCount;
  logic             stHitsLoad, ldTracked, ltFull;

  spec_ckpt_ctrl #(.SB_DEPTH(SB_DEPTH)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .commitReq  (commitReq),
    .rollbackReq(rollbackReq),
    .stEn       (stEn),
    .ldEn       (ldEn),
    .sbCount    (sbCount),
    .stHitsLoad (stHitsLoad),
    .ldTracked  (ldTracked),
    .ltFull     (ltFull),
    .strobe     (strobe),
    .busy       (busy),
    .overflow   (overflow),
    .aliasViol  (aliasViol)
  );

  spec_ckpt_datapath #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .SB_DEPTH(SB_DEPTH), .LT_DEPTH(LT_DEPTH)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .stAddr    (stAddr),
    .stData    (stData),
    .ldAddr    (ldAddr),
    .sbCount   (sbCount),
    .stHitsLoad(stHitsLoad),
    .ldTracked (ldTracked),
    .ltFull    (ltFull),
    .headAddr  (memWrAddr),
    .headData  (memWrData)
  );

  assign memWrEn = busy;

endmodule

// File: tb/spec_ckpt_unit_tb.sv
module spec_ckpt_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  rdAddr, wrAddr;
  logic [31:0] rdData, wrData, stData, memWrData;
  logic        wrEn, stEn, ldEn, commitReq, rollbackReq;
  logic [15:0] stAddr, ldAddr, memWrAddr;
  logic        memWrEn, busy, overflow, aliasViol;

  int  nChecks = 0;
  int  nErr    = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_ckpt_unit dut_i (
    .clk(clk), .rstN(rstN), .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stEn(stEn), .stAddr(stAddr), .stData(stData),
    .ldEn(ldEn), .ldAddr(ldAddr),
    .commitReq(commitReq), .rollbackReq(rollbackReq),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .busy(busy), .overflow(overflow), .aliasViol(aliasViol)
  );

  // {register index, value}
  localparam logic [37:0] REG_VEC [8] = '{
    {6'd0,  32'h1000_0A00}, {6'd1,  32'h2000_0B11}, {6'd2,  32'h3000_0C22},
    {6'd3,  32'h4000_0D33}, {6'd7,  32'h5000_0E77}, {6'd10, 32'h6000_0FAA},
    {6'd33, 32'h7000_1033}, {6'd63, 32'h8000_1163}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic readReg(input logic [5:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic doStore(input logic [15:0] a, input logic [31:0] d);
    stEn = 1'b1; stAddr = a; stData = d;
    step();
    stEn = 1'b0;
  endtask

  task automatic doLoad(input logic [15:0] a);
    ldEn = 1'b1; ldAddr = a;
    step();
    ldEn = 1'b0;
  endtask

  task automatic pulseCommit();
    commitReq = 1'b1; step(); commitReq = 1'b0;
  endtask

  task automatic pulseRollback();
    rollbackReq = 1'b1; step(); rollbackReq = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nErr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rstN = 1'b0; wrEn = 0; stEn = 0; ldEn = 0; commitReq = 0; rollbackReq = 0;
    rdAddr = '0; wrAddr = '0; wrData = '0; stAddr = '0; stData = '0; ldAddr = '0;
    repeat (3) step();
    rstN = 1'b1;
    step();

    // R1 reset state
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 overflow", {31'd0, overflow}, 0);
    check("R1 aliasViol", {31'd0, aliasViol}, 0);
    check("R1 memWrEn", {31'd0, memWrEn}, 0);
    readReg(6'd5, v);  check("R1 reg5", v, 0);
    readReg(6'd63, v); check("R1 reg63", v, 0);

    // R2 vector table: write all, then read back
    for (int i = 0; i < 8; i++) begin
      wrEn = 1'b1; wrAddr = REG_VEC[i][37:32]; wrData = REG_VEC[i][31:0];
      step();
    end
    wrEn = 1'b0;
    for (int i = 0; i < 8; i++) begin
      readReg(REG_VEC[i][37:32], v);
      check("R2 table read", v, REG_VEC[i][31:0]);
    end

    // R6 empty commit: no busy
    pulseCommit();
    check("R6 empty commit busy", {31'd0, busy}, 0);

    // R4 write in commit cycle lands only in working copy
    commitReq = 1'b1; wrEn = 1'b1; wrAddr = 6'd63; wrData = 32'hDEAD_0063;
    step();
    commitReq = 1'b0; wrEn = 1'b0;
    readReg(6'd63, v); check("R4 working after commit write", v, 32'hDEAD_0063);
    wrEn = 1'b1; wrAddr = 6'd3; wrData = 32'h3333_3333; step(); wrEn = 1'b0;
    readReg(6'd3, v); check("R2 overwrite", v, 32'h3333_3333);

    // R3 rollback restores; write in rollback cycle dropped
    rollbackReq = 1'b1; wrEn = 1'b1; wrAddr = 6'd1; wrData = 32'h1111_1111;
    step();
    rollbackReq = 1'b0; wrEn = 1'b0;
    readReg(6'd63, v); check("R4 shadow kept pre-write value", v, REG_VEC[7][31:0]);
    readReg(6'd3, v);  check("R3 reg3 restored", v, REG_VEC[3][31:0]);
    readReg(6'd1, v);  check("R3 write in rollback cycle dropped", v, REG_VEC[1][31:0]);

    // R5 / R6 / R12 / R13 store hold and drain
    for (int i = 0; i < 3; i++) doStore(16'h0100 + 16'(i), 32'hA000 + 32'(i));
    step();
    check("R5 no memory write before commit", {31'd0, memWrEn}, 0);
    pulseCommit();
    check("R6 busy drain 0", {31'd0, busy}, 1);
    check("R6 drain0 addr", {16'd0, memWrAddr}, 32'h0100);
    check("R6 drain0 data", memWrData, 32'hA000);
    stEn = 1'b1; stAddr = 16'h0200; stData = 32'hB200; commitReq = 1'b1;
    step();
    stEn = 1'b0; commitReq = 1'b0;
    check("R6 drain1 addr", {16'd0, memWrAddr}, 32'h0101);
    check("R6 drain1 en", {31'd0, memWrEn}, 1);
    step();
    check("R6 drain2 addr", {16'd0, memWrAddr}, 32'h0102);
    check("R6 drain2 data", memWrData, 32'hA002);
    step();
    check("R12 busy ends after 3 despite commit while busy", {31'd0, busy}, 0);
    pulseCommit();
    check("R13 late store drains on next commit", {16'd0, memWrAddr}, 32'h0200);
    check("R13 busy", {31'd0, busy}, 1);
    step();
    check("R13 single entry drain", {31'd0, busy}, 0);

    // R7 rollback discards stores
    doStore(16'h0300, 32'h1);
    doStore(16'h0301, 32'h2);
    pulseRollback();
    pulseCommit();
    check("R7 nothing drained after rollback", {31'd0, busy}, 0);
    check("R7 memWrEn", {31'd0, memWrEn}, 0);

    // R8 overflow
    for (int i = 0; i < 8; i++) doStore(16'h0400 + 16'(i), 32'hC000 + 32'(i));
    check("R8 no overflow at 8", {31'd0, overflow}, 0);
    doStore(16'h0500, 32'hFFFF);
    check("R8 overflow on ninth", {31'd0, overflow}, 1);
    pulseCommit();
    check("R8 overflow cleared by commit", {31'd0, overflow}, 0);
    for (int i = 0; i < 8; i++) begin
      check("R8 drain busy", {31'd0, busy}, 1);
      check("R8 drain addr", {16'd0, memWrAddr}, 32'h0400 + 32'(i));
      step();
    end
    check("R8 dropped store not drained", {31'd0, busy}, 0);

    // R9 / R11 alias detection
    doLoad(16'h0600);
    doStore(16'h0601, 32'h5);
    check("R9 no alias on other address", {31'd0, aliasViol}, 0);
    doStore(16'h0600, 32'h6);
    check("R9 alias set", {31'd0, aliasViol}, 1);
    step();
    check("R9 alias sticky", {31'd0, aliasViol}, 1);
    pulseRollback();
    check("R11 rollback clears alias", {31'd0, aliasViol}, 0);
    doStore(16'h0600, 32'h7);
    check("R11 tracker cleared by rollback", {31'd0, aliasViol}, 0);
    pulseRollback();

    // R10 tracker capacity and repeats
    for (int i = 0; i < 7; i++) doLoad(16'h0700 + 16'(i));
    doLoad(16'h0700);
    doLoad(16'h0707);
    check("R10 repeat uses no slot", {31'd0, aliasViol}, 0);
    doStore(16'h0707, 32'h9);
    check("R10 eighth address tracked", {31'd0, aliasViol}, 1);
    pulseRollback();
    for (int i = 0; i < 8; i++) doLoad(16'h0720 + 16'(i));
    check("R10 full tracker no alias yet", {31'd0, aliasViol}, 0);
    doLoad(16'h0780);
    check("R10 new load when full flags alias", {31'd0, aliasViol}, 1);
    pulseRollback();

    // R11 commit clears tracker
    doLoad(16'h0800);
    pulseCommit();
    doStore(16'h0800, 32'hA);
    check("R11 commit clears tracker", {31'd0, aliasViol}, 0);
    pulseRollback();

    // R12 rollback wins over commit
    wrEn = 1'b1; wrAddr = 6'd2; wrData = 32'h2222_2222; step(); wrEn = 1'b0;
    doStore(16'h0900, 32'hB);
    commitReq = 1'b1; rollbackReq = 1'b1;
    step();
    commitReq = 1'b0; rollbackReq = 1'b0;
    check("R12 no drain when both requested", {31'd0, busy}, 0);
    readReg(6'd2, v); check("R12 rollback applied", v, REG_VEC[2][31:0]);
    pulseCommit();
    check("R12 store discarded", {31'd0, busy}, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule